// File: doc/BRIEF.md
# Receive Filter Indirect Access Port

This block gives software a narrow window into the storage behind a receive packet filter. Two kinds of storage sit behind the window. The first is a six-byte station address that the filter compares against for exact matches. The second is a 256-byte multicast hash table. Software does not address this storage through the bus address. It first writes a filter control register whose low field selects a byte address inside the filter space. Each access to the 16-bit data port then moves one word at that address.

The block decodes the selected address and splits or joins the two byte lanes of each word. It reports accesses that fall outside the legal words. The filter control register also carries two enable bits. The multicast-hash enable is stored and driven to the packet filter. The unicast-hash enable is not supported, so any attempt to set it is reported. The station address is driven continuously as a flat vector for the match logic.

Top module: `rx_filt_port`

## Requirements
- R1: After reset, `station_addr` is 0, `mhash_en` is 0, the address field is 0x000, both error outputs are low, and every word of the hash table reads 0.
- R2: A data write with the address field at 0x000, 0x002 or 0x004 stores station bytes (n, n+1), where n is the address. Bits 7:0 go to byte n and bits 15:8 go to byte n+1. Byte k appears on `station_addr[8k+7:8k]` in the cycle after the write edge.
- R3: A data read (`dat_re` high, `dat_we` low) raises `rd_valid` for exactly the next cycle. `rd_data` then holds the selected word in the same lane packing as a write.
- R4: Even addresses from 0x100 to 0x1FE select hash bytes (a-0x100) in bits 7:0 and (a-0x100+1) in bits 15:8. A write there changes only that word, and a read returns it.
- R5: An odd address from 0x101 to 0x1FF is illegal for both reads and writes. `acc_err` pulses in the cycle after the access, a read returns 0, and a write changes no storage.
- R6: Every other address is illegal in the same way as R5. This covers odd addresses below 0x006, addresses 0x006 to 0x0FF, and addresses from 0x200 up.
- R7: Control write bit 12 is the multicast-hash enable. Its value appears on `mhash_en` in the cycle after the control write.
- R8: A control write with bit 13 set (unicast-hash enable) raises `ucast_err` for the next cycle. The bit is not stored, and the address field and bit 12 of that write still load.
- R9: Control write bits 9:0 are the address field. A data access uses the field value held before its clock edge. A control write in the same cycle only affects later accesses.
- R10: When `dat_we` and `dat_re` are both high, only the write happens: `rd_valid` stays low in the next cycle.
- R11: `acc_err` and `ucast_err` are high only in the cycle directly after an access or control write that causes them.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ctl_we | input | 1 | Write strobe for the filter control register |
| ctl_wdata | input | CTL_W (16) | Control value: bits 9:0 address, bit 12 multicast hash enable, bit 13 unicast hash enable |
| dat_we | input | 1 | Data port write strobe |
| dat_re | input | 1 | Data port read strobe |
| dat_wdata | input | 16 | Data port write word |
| rd_valid | output | 1 | Read data valid, one cycle after a read |
| rd_data | output | 16 | Read word |
| acc_err | output | 1 | Illegal data access pulse |
| ucast_err | output | 1 | Unsupported unicast hash enable pulse |
| station_addr | output | 8*STA_BYTES (48) | Stored station address, byte k at bits 8k+7:8k |
| mhash_en | output | 1 | Multicast hash enable to the packet filter |

## Verification
The station words are written with distinct byte values in each lane, so a swapped lane or word would show on `station_addr` and on read-back. The hash table is tried at its first word, its last word and a middle word. An untouched neighbour is then read, which separates correct index arithmetic from aliasing. Illegal addresses are placed on both sides of each legal region, including odd addresses inside it, and each illegal access is followed by a read of the storage it could have changed. A control write issued in the same cycle as a data write, and a cycle with both strobes high, show which address and which operation win.

// File: rtl/rxf_pkg.sv
// Package: shared types and field positions for the receive filter access port.
// Assumes the filter control register carries its address field in the low bits.
package rxf_pkg;
    // Region selected by the current address field
    typedef enum logic [1:0] {
        RGN_NONE = 2'd0,
        RGN_STA  = 2'd1,
        RGN_HASH = 2'd2
    } rgn_e;

    // Bit positions inside a filter control write
    localparam int CTL_MHASH_BIT = 12;
    localparam int CTL_UHASH_BIT = 13;
endpackage

// File: rtl/rxf_addr_decode.sv
// Address decoder: maps a filter byte address to a storage region and word index.
// Assumes both regions are word aligned; any odd address is illegal.
module rxf_addr_decode
    import rxf_pkg::*;
#(
    parameter int ADDR_W     = 10,
    parameter int STA_BYTES  = 6,
    parameter int HASH_BASE  = 256,
    parameter int HASH_BYTES = 256,
    parameter int IDX_W      = 7
) (
    input  logic [ADDR_W-1:0] addr,
    output rgn_e              rgn,
    output logic [IDX_W-1:0]  widx
);
    localparam logic [ADDR_W:0] STA_END = (ADDR_W+1)'(STA_BYTES);
    localparam logic [ADDR_W:0] HASH_LO = (ADDR_W+1)'(HASH_BASE);
    localparam logic [ADDR_W:0] HASH_HI = (ADDR_W+1)'(HASH_BASE + HASH_BYTES);

    logic [ADDR_W:0] addr_x;
    logic [ADDR_W:0] hash_off;

    assign addr_x   = {1'b0, addr};
    assign hash_off = addr_x - HASH_LO;

    // Classify the address and derive the word index within its region
    always_comb begin
        rgn  = RGN_NONE;
        widx = '0;
        if (!addr_x[0]) begin
            if (addr_x < STA_END) begin
                rgn  = RGN_STA;
                widx = IDX_W'(addr_x >> 1);
            end else if (addr_x >= HASH_LO && addr_x < HASH_HI) begin
                rgn  = RGN_HASH;
                widx = IDX_W'(hash_off >> 1);
            end
        end
    end
endmodule

// File: rtl/rxf_station_store.sv
// Station address storage: word-wide writes, flat byte output, combinational word read.
// Assumes the even byte of each word sits in the low lane.
module rxf_station_store #(
    parameter int STA_BYTES = 6,
    parameter int IDX_W     = 7
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   we,
    input  logic [IDX_W-1:0]       widx,
    input  logic [15:0]            wdata,
    output logic [8*STA_BYTES-1:0] station,
    output logic [15:0]            rword
);
    localparam int STA_WORDS = STA_BYTES / 2;

    logic [STA_WORDS-1:0][15:0] word_q;

    // Store one word per write, clear on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            word_q <= '0;
        end else if (we) begin
            for (int w = 0; w < STA_WORDS; w++) begin
                if (widx == IDX_W'(w)) word_q[w] <= wdata;
            end
        end
    end

    // Word w holds bytes 2w (low lane) and 2w+1 (high lane)
    assign station = word_q;

    // Select the addressed word for reads
    always_comb begin
        rword = '0;
        for (int w = 0; w < STA_WORDS; w++) begin
            if (widx == IDX_W'(w)) rword = word_q[w];
        end
    end
endmodule

// File: rtl/rxf_hash_store.sv
// Multicast hash table storage, kept as 16-bit words of two byte lanes.
// Assumes the index is already checked to lie inside the table.
module rxf_hash_store #(
    parameter int HASH_BYTES = 256,
    parameter int IDX_W      = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             we,
    input  logic [IDX_W-1:0] widx,
    input  logic [15:0]      wdata,
    output logic [15:0]      rword
);
    localparam int HASH_WORDS = HASH_BYTES / 2;

    logic [15:0] mem_q [HASH_WORDS];

    // Write one word, clear the whole table on reset
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < HASH_WORDS; i++) mem_q[i] <= '0;
        end else if (we) begin
            mem_q[widx] <= wdata;
        end
    end

    // Combinational word read
    assign rword = mem_q[widx];
endmodule

// File: rtl/rx_filt_port.sv
// Top: filter control register plus indirect 16-bit data port into the
// station address and multicast hash storage.
// Assumes data accesses use the address field value held before their edge;
// a simultaneous write and read strobe performs the write only.
module rx_filt_port
    import rxf_pkg::*;
#(
    parameter int CTL_W      = 16,
    parameter int ADDR_W     = 10,
    parameter int STA_BYTES  = 6,
    parameter int HASH_BASE  = 256,
    parameter int HASH_BYTES = 256
) (
    input  logic                   clk,
    input  logic                   rst_n,
    input  logic                   ctl_we,
    input  logic [CTL_W-1:0]       ctl_wdata,
    input  logic                   dat_we,
    input  logic                   dat_re,
    input  logic [15:0]            dat_wdata,
    output logic                   rd_valid,
    output logic [15:0]            rd_data,
    output logic                   acc_err,
    output logic                   ucast_err,
    output logic [8*STA_BYTES-1:0] station_addr,
    output logic                   mhash_en
);
    localparam int HASH_WORDS = HASH_BYTES / 2;
    localparam int IDX_W      = (HASH_WORDS > 4) ? $clog2(HASH_WORDS) : 2;

    logic [ADDR_W-1:0] addr_q;
    logic              mhash_q;
    logic              ucast_q;
    logic              rvalid_q;
    logic [15:0]       rdata_q;
    logic              err_q;
    rgn_e              rgn;
    logic [IDX_W-1:0]  widx;
    logic [15:0]       sta_word;
    logic [15:0]       hash_word;
    logic              rd_go;
    logic              any_acc;
    logic              ctl_unused;

    assign ctl_unused = ^ctl_wdata;

    // Filter control register: address field and multicast hash enable
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            addr_q  <= '0;
            mhash_q <= 1'b0;
        end else if (ctl_we) begin
            addr_q  <= ctl_wdata[ADDR_W-1:0];
            mhash_q <= ctl_wdata[CTL_MHASH_BIT];
        end
    end

    // Flag any attempt to turn on unicast hashing
    always_ff @(posedge clk) begin
        if (!rst_n) ucast_q <= 1'b0;
        else        ucast_q <= ctl_we && ctl_wdata[CTL_UHASH_BIT];
    end

    rxf_addr_decode #(
        .ADDR_W    (ADDR_W),
        .STA_BYTES (STA_BYTES),
        .HASH_BASE (HASH_BASE),
        .HASH_BYTES(HASH_BYTES),
        .IDX_W     (IDX_W)
    ) u_dec (
        .addr(addr_q),
        .rgn (rgn),
        .widx(widx)
    );

    rxf_station_store #(
        .STA_BYTES(STA_BYTES),
        .IDX_W    (IDX_W)
    ) u_sta (
        .clk    (clk),
        .rst_n  (rst_n),
        .we     (dat_we && rgn == RGN_STA),
        .widx   (widx),
        .wdata  (dat_wdata),
        .station(station_addr),
        .rword  (sta_word)
    );

    rxf_hash_store #(
        .HASH_BYTES(HASH_BYTES),
        .IDX_W     (IDX_W)
    ) u_hash (
        .clk  (clk),
        .rst_n(rst_n),
        .we   (dat_we && rgn == RGN_HASH),
        .widx (widx),
        .wdata(dat_wdata),
        .rword(hash_word)
    );

    assign rd_go   = dat_re && !dat_we;
    assign any_acc = dat_re || dat_we;

    // Register read data and its valid strobe; illegal reads return zero
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rvalid_q <= 1'b0;
            rdata_q  <= '0;
        end else begin
            rvalid_q <= rd_go;
            if (rd_go) begin
                case (rgn)
                    RGN_STA:  rdata_q <= sta_word;
                    RGN_HASH: rdata_q <= hash_word;
                    default:  rdata_q <= '0;
                endcase
            end
        end
    end

    // One-cycle pulse for an access to an illegal address
    always_ff @(posedge clk) begin
        if (!rst_n) err_q <= 1'b0;
        else        err_q <= any_acc && rgn == RGN_NONE;
    end

    assign rd_valid  = rvalid_q;
    assign rd_data   = rdata_q;
    assign acc_err   = err_q;
    assign ucast_err = ucast_q;
    assign mhash_en  = mhash_q;
endmodule

// File: rtl/rxf_port_checker.sv
// Checker: temporal properties of the access port, bound to the top module.
module rxf_port_checker
    import rxf_pkg::*;
#(
    parameter int CTL_W     = 16,
    parameter int STA_BYTES = 6
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic                   ctl_we,
    input logic [CTL_W-1:0]       ctl_wdata,
    input logic                   dat_we,
    input logic                   dat_re,
    input logic                   rd_valid,
    input logic [15:0]            rd_data,
    input logic                   acc_err,
    input logic                   ucast_err,
    input logic [8*STA_BYTES-1:0] station_addr,
    input logic                   mhash_en
);
    AST_RVALID_NEEDS_READ: assert property (@(posedge clk) disable iff (!rst_n)
        rd_valid |-> $past(dat_re && !dat_we)); // R3
    AST_BAD_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (rd_valid && acc_err) |-> rd_data == 16'h0000); // R5
    AST_ERR_NEEDS_ACCESS: assert property (@(posedge clk) disable iff (!rst_n)
        acc_err |-> $past(dat_we || dat_re)); // R11
    AST_STATION_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(dat_we) |-> $stable(station_addr)); // R2
    AST_MHASH_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !$past(ctl_we) |-> $stable(mhash_en)); // R7
    AST_UCAST_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
        ucast_err |-> $past(ctl_we && ctl_wdata[CTL_UHASH_BIT])); // R8
    AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
        $past(dat_we) |-> !rd_valid); // R10
endmodule

bind rx_filt_port rxf_port_checker #(
    .CTL_W    (CTL_W),
    .STA_BYTES(STA_BYTES)
) u_chk (.*);

// File: tb/rx_filt_port_bench.sv
// Directed bench for the receive filter access port.
module rx_filt_port_bench;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctl_we = 1'b0;
    logic [15:0] ctl_wdata = '0;
    logic        dat_we = 1'b0;
    logic        dat_re = 1'b0;
    logic [15:0] dat_wdata = '0;
    logic        rd_valid;
    logic [15:0] rd_data;
    logic        acc_err;
    logic        ucast_err;
    logic [47:0] station_addr;
    logic        mhash_en;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #5 clk = ~clk;

    rx_filt_port u_rx_filt_port (.*);

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        total++;
        if (act !== exp) begin
            bad++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    task automatic set_ctl(input logic [15:0] v);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = v;
        @(negedge clk);
        ctl_we = 1'b0;
    endtask

    task automatic wr(input logic [15:0] d, output logic e);
        @(negedge clk);
        dat_we = 1'b1; dat_wdata = d;
        @(negedge clk);
        dat_we = 1'b0;
        e = acc_err;
    endtask

    task automatic rd(output logic [15:0] d, output logic v, output logic e);
        @(negedge clk);
        dat_re = 1'b1;
        @(negedge clk);
        dat_re = 1'b0;
        d = rd_data; v = rd_valid; e = acc_err;
    endtask

    task automatic t_reset();
        logic [15:0] d; logic v, e;
        check("R1 station", {16'h0, station_addr}, 64'h0);
        check("R1 mhash", {63'h0, mhash_en}, 64'h0);
        check("R1 errs", {62'h0, acc_err, ucast_err}, 64'h0);
        set_ctl(16'h01FE);
        rd(d, v, e);
        check("R1 hash zero", {47'h0, v, d}, {47'h0, 1'b1, 16'h0000});
    endtask

    task automatic t_station();
        logic [15:0] d; logic v, e;
        set_ctl(16'h0000); wr(16'h2211, e);
        check("R2 no err", {63'h0, e}, 64'h0);
        set_ctl(16'h0002); wr(16'h4433, e);
        set_ctl(16'h0004); wr(16'h6655, e);
        check("R2 station", {16'h0, station_addr}, 64'h0000_6655_4433_2211);
        set_ctl(16'h0002); rd(d, v, e);
        check("R3 read word1", {46'h0, e, v, d}, {46'h0, 1'b0, 1'b1, 16'h4433});
        @(negedge clk);
        check("R3 valid one cycle", {63'h0, rd_valid}, 64'h0);
    endtask

    task automatic t_hash();
        logic [15:0] d; logic v, e;
        set_ctl(16'h0100); wr(16'hA1B2, e);
        set_ctl(16'h01FE); wr(16'hC3D4, e);
        set_ctl(16'h0150); wr(16'h1357, e);
        check("R4 write no err", {63'h0, e}, 64'h0);
        set_ctl(16'h0100); rd(d, v, e);
        check("R4 first word", {48'h0, d}, 64'hA1B2);
        set_ctl(16'h01FE); rd(d, v, e);
        check("R4 last word", {48'h0, d}, 64'hC3D4);
        set_ctl(16'h0150); rd(d, v, e);
        check("R4 mid word", {48'h0, d}, 64'h1357);
        set_ctl(16'h0102); rd(d, v, e);
        check("R4 neighbour untouched", {48'h0, d}, 64'h0);
    endtask

    task automatic t_odd_hash();
        logic [15:0] d; logic v, e;
        set_ctl(16'h0101); wr(16'hFFFF, e);
        check("R5 odd write err", {63'h0, e}, 64'h1);
        @(negedge clk);
        check("R11 err one cycle", {63'h0, acc_err}, 64'h0);
        set_ctl(16'h0100); rd(d, v, e);
        check("R5 storage kept", {48'h0, d}, 64'hA1B2);
        set_ctl(16'h0151); rd(d, v, e);
        check("R5 odd read", {46'h0, e, v, d}, {46'h0, 1'b1, 1'b1, 16'h0});
    endtask

    task automatic t_out_range();
        logic [15:0] d; logic v, e;
        set_ctl(16'h0003); wr(16'hEEEE, e);
        check("R6 odd station err", {63'h0, e}, 64'h1);
        set_ctl(16'h0006); wr(16'hEEEE, e);
        check("R6 0x006 err", {63'h0, e}, 64'h1);
        set_ctl(16'h00FE); wr(16'hEEEE, e);
        check("R6 0x0FE err", {63'h0, e}, 64'h1);
        check("R6 station kept", {16'h0, station_addr}, 64'h0000_6655_4433_2211);
        set_ctl(16'h0200); rd(d, v, e);
        check("R6 0x200 read", {46'h0, e, v, d}, {46'h0, 1'b1, 1'b1, 16'h0});
    endtask

    task automatic t_enables();
        logic [15:0] d; logic v, e;
        set_ctl(16'h1000);
        check("R7 mhash on", {63'h0, mhash_en}, 64'h1);
        check("R8 no ucast", {63'h0, ucast_err}, 64'h0);
        set_ctl(16'h2004);
        check("R8 ucast pulse", {63'h0, ucast_err}, 64'h1);
        check("R7 mhash off", {63'h0, mhash_en}, 64'h0);
        @(negedge clk);
        check("R11 ucast one cycle", {63'h0, ucast_err}, 64'h0);
        rd(d, v, e);
        check("R8 address loaded", {48'h0, d}, 64'h6655);
    endtask

    task automatic t_same_cycle();
        logic [15:0] d; logic v, e;
        set_ctl(16'h0000);
        @(negedge clk);
        ctl_we = 1'b1; ctl_wdata = 16'h0002;
        dat_we = 1'b1; dat_wdata = 16'h7788;
        @(negedge clk);
        ctl_we = 1'b0; dat_we = 1'b0;
        check("R9 old address used", {16'h0, station_addr}, 64'h0000_6655_4433_7788);
        @(negedge clk);
        dat_we = 1'b1; dat_re = 1'b1; dat_wdata = 16'h99AA;
        @(negedge clk);
        dat_we = 1'b0; dat_re = 1'b0;
        check("R10 no read", {63'h0, rd_valid}, 64'h0);
        rd(d, v, e);
        check("R10 write done", {48'h0, d}, 64'h99AA);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        t_reset();
        t_station();
        t_hash();
        t_odd_hash();
        t_out_range();
        t_enables();
        t_same_cycle();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            total++;
            bad++;
            $display("FAIL watchdog actual=hung expected=done");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule